// File: doc/BRIEF.md
# Fractional-Baud Oversampling UART Receiver

This block turns an asynchronous serial receive line into parallel bytes while running on a single system clock. The bit period is programmed as a fixed-point number of system clocks with a 16-bit whole part and an 8-bit fraction. Because of that fraction, rates with no integer ratio to the clock can still be received. For example, 9600 baud from a 32.768 kHz clock is about 3.4133 clocks per bit. A phase register counts elapsed time in 1/256-clock units and wraps by exactly the programmed period at each bit boundary, so rounding error never builds up.

A falling edge on the synchronised line starts a frame and clears the phase, so the timing is re-aligned to every start bit. The start bit is confirmed at its centre. Data bits, the optional parity bit and the stop bit are then decided near their centres. An oversampling select sets how far the two outer vote samples sit from the centre sample: one sixteenth or one eighth of a bit. A third setting uses the centre sample alone, which suits very low clock-per-bit ratios. The frame format can carry 7 or 8 data bits, with optional even or odd parity.

Top module: `uart_frac_rx`

## Requirements
- R1: `rxLine` passes through two flip-flop stages before any logic uses it. Data bits are taken least-significant first. Each received frame produces exactly one single-cycle `rxValid` pulse, one cycle after the stop-bit centre sample, with the byte on `rxData` in that cycle.
- R2: `divisor` gives clocks per bit: bits [23:8] are the whole part and bits [7:0] are the fraction in 1/256 steps. Frames sent at non-integer periods (10.5 and 874/256 clocks per bit) are received correctly. The programmed period must be at least 4 clocks in the 16x and 8x modes, and at least 2 clocks in the centre-only mode.
- R3: `osrSel` encoding: 0 places the outer vote samples one sixteenth of a bit from the centre, 1 places them one eighth of a bit from it, and 2 or 3 uses the centre sample alone.
- R4: With `osrSel` 0 or 1, each data and parity bit is the 2-of-3 majority of its three samples. A one-clock glitch at a bit centre does not change the received bit.
- R5: A start bit is accepted only if the line is still low at the centre of the start bit. A shorter low pulse produces no `rxValid` and no flag.
- R6: The bit timing restarts on every accepted start edge. Frames from a transmitter whose bit period is 3% off the programmed one, sent with idle gaps of 0 to 7 clocks, are received correctly.
- R7: With `sevenBit`=1 the frame has 7 data bits and `rxData[7]` reads 0. With `sevenBit`=0 it has 8 data bits.
- R8: With `parityEn`=1, one parity bit follows the data bits. `parityOdd`=0 selects even parity and 1 selects odd parity. On a mismatch, `parityErr` is high in the same cycle as `rxValid`. With `parityEn`=0, `parityErr` stays 0.
- R9: If the stop-bit sample is low, `frameErr` is high in the same cycle as `rxValid`. The receiver then waits for the line to return high before it looks for a new start edge.
- R10: While `rstN` is low, and after reset until the first frame, `rxValid`, `frameErr`, `parityErr` and `rxData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial receive line, idle high |
| divisor | input | 24 | Clocks per bit, 16.8 fixed point |
| osrSel | input | 2 | Vote sample spacing: 0 = 1/16 bit, 1 = 1/8 bit, 2 or 3 = centre only |
| sevenBit | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| parityEn | input | 1 | 1 = a parity bit follows the data bits |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rxData | output | 8 | Received byte, valid when rxValid is high |
| rxValid | output | 1 | Single-cycle strobe marking a received frame |
| frameErr | output | 1 | Stop bit read low; qualifies rxValid |
| parityErr | output | 1 | Parity mismatch; qualifies rxValid |

## Verification
Frames are sent in every sampling mode:
- an integer period of 16 clocks,
- a fractional period of 10.5 clocks,
- the 874/256-clock period at which only the centre sample fits.

Together these separate a correct fractional wrap from one that truncates the fraction. Back-to-back frames from a transmitter 3% fast or slow, with gaps of 0 to 7 clocks, show whether timing is re-aligned per frame or left free-running. Single-clock glitches at bit centres, short false-start pulses, 7-bit frames with correct and wrong even or odd parity, and a stop bit held low followed by a long low period each exercise one decision path of the controller. A behavioural queue of expected frames is compared on every clock, so a missing, duplicated or stretched valid pulse is caught as well as a wrong byte or flag.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rxState_t;

  // Events reported by the datapath to the controller.
  typedef struct packed {
    logic fallEdge;
    logic midHit;
    logic bitEnd;
    logic lineHigh;
  } rxEvt_t;

  // Strobes issued by the controller to the datapath.
  typedef struct packed {
    logic       restart;
    logic       takeBit;
    logic       takePar;
    logic       endFrame;
    logic [2:0] bitIdx;
  } rxCtl_t;
endpackage

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int FRAC_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxLine,
  input  logic [INT_W+FRAC_W-1:0] divisor,
  input  logic [1:0]              osrSel,
  input  logic                    sevenBit,
  input  logic                    parityEn,
  input  logic                    parityOdd,
  input  rxCtl_t                  ctl,
  output rxEvt_t                  evt,
  output logic [7:0]              rxData,
  output logic                    rxValid,
  output logic                    frameErr,
  output logic                    parityErr
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int PH_W  = DIV_W + 1;
  localparam logic [PH_W-1:0] ONE = PH_W'(1) << FRAC_W;
  // Phase loaded on a start edge: time already spent in the synchroniser.
  localparam logic [PH_W-1:0] SYNC_COMP = PH_W'(SYNC_STAGES - 1) << FRAC_W;

  // R1: synchroniser chain, idle high
  logic [SYNC_STAGES-1:0] syncQ;
  logic rxS, rxPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxLine};
      rxPrev <= rxS;
    end
  end
  assign rxS = syncQ[SYNC_STAGES-1];

  // Fractional bit-phase register (1/2^FRAC_W clock units)
  logic [PH_W-1:0]  phase, phNext, divExt, midMark, earlyMark, lateMark, stepExt;
  logic [2:0]       osrLog;
  logic             centreOnly, crossEarly, crossMid, crossLate, hitEnd;

  always_comb begin
    centreOnly = osrSel[1];
    osrLog     = (osrSel == 2'd0) ? 3'd4 : 3'd3;
    divExt     = {1'b0, divisor};
    stepExt    = divExt >> osrLog;
    midMark    = divExt >> 1;
    earlyMark  = midMark - stepExt;
    lateMark   = midMark + stepExt;
    phNext     = phase + ONE;
    hitEnd     = phNext >= divExt;
    crossEarly = (phase < earlyMark) && (phNext >= earlyMark);
    crossMid   = (phase < midMark)   && (phNext >= midMark);
    crossLate  = (phase < lateMark)  && (phNext >= lateMark);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            phase <= '0;
    else if (ctl.restart) phase <= SYNC_COMP;
    else if (hitEnd)      phase <= phNext - divExt;
    else                  phase <= phNext;
  end

  // Three samples around the bit centre
  logic s0, s1, s2, voteBit;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s0 <= 1'b1; s1 <= 1'b1; s2 <= 1'b1;
    end else begin
      if (crossEarly) s0 <= rxS;
      if (crossMid)   s1 <= rxS;
      if (crossLate)  s2 <= rxS;
    end
  end
  assign voteBit = centreOnly ? s1 : ((s0 & s1) | (s0 & s2) | (s1 & s2));

  assign evt.fallEdge = rxPrev & ~rxS;
  assign evt.midHit   = crossMid;
  assign evt.bitEnd   = hitEnd;
  assign evt.lineHigh = rxS;

  // Assembly and result registers
  logic [7:0] shReg;
  logic       parBit, dataXor;
  assign dataXor = sevenBit ? ^shReg[6:0] : ^shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      parBit    <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      if (ctl.restart) shReg <= '0;
      else if (ctl.takeBit) shReg[ctl.bitIdx] <= voteBit;
      if (ctl.takePar) parBit <= voteBit;
      rxValid   <= ctl.endFrame;
      frameErr  <= ctl.endFrame & ~rxS;
      parityErr <= ctl.endFrame & parityEn & (dataXor ^ parBit ^ parityOdd);
      if (ctl.endFrame) rxData <= sevenBit ? {1'b0, shReg[6:0]} : shReg;
    end
  end
endmodule

// File: rtl/urx_control.sv
module urx_control
  import urx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sevenBit,
  input  logic   parityEn,
  input  rxEvt_t evt,
  output rxCtl_t ctl
);
  rxState_t   state, stateNext;
  logic [2:0] bitIdx;
  logic       lastBit;

  assign lastBit = (bitIdx == (sevenBit ? 3'd6 : 3'd7));

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (evt.fallEdge) stateNext = S_START;
      S_START: if (evt.midHit && evt.lineHigh) stateNext = S_IDLE;   // R5
               else if (evt.bitEnd) stateNext = S_DATA;
      S_DATA:  if (evt.bitEnd && lastBit) stateNext = parityEn ? S_PAR : S_STOP;
      S_PAR:   if (evt.bitEnd) stateNext = S_STOP;
      S_STOP:  if (evt.midHit) stateNext = evt.lineHigh ? S_IDLE : S_HOLD;
      S_HOLD:  if (evt.lineHigh) stateNext = S_IDLE;                // R9
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == S_START) bitIdx <= '0;
      else if (state == S_DATA && evt.bitEnd) bitIdx <= bitIdx + 3'd1;
    end
  end

  always_comb begin
    ctl.restart  = (state == S_IDLE) && evt.fallEdge;   // R6 re-align
    ctl.takeBit  = (state == S_DATA) && evt.bitEnd;
    ctl.takePar  = (state == S_PAR)  && evt.bitEnd;
    ctl.endFrame = (state == S_STOP) && evt.midHit;
    ctl.bitIdx   = bitIdx;
  end
endmodule

// File: rtl/uart_frac_rx.sv
module uart_frac_rx
  import urx_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int FRAC_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxLine,
  input  logic [INT_W+FRAC_W-1:0] divisor,
  input  logic [1:0]              osrSel,
  input  logic                    sevenBit,
  input  logic                    parityEn,
  input  logic                    parityOdd,
  output logic [7:0]              rxData,
  output logic                    rxValid,
  output logic                    frameErr,
  output logic                    parityErr
);
  rxEvt_t evt;
  rxCtl_t ctl;

  urx_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .divisor(divisor), .osrSel(osrSel),
    .sevenBit(sevenBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .ctl(ctl), .evt(evt), .rxData(rxData), .rxValid(rxValid),
    .frameErr(frameErr), .parityErr(parityErr)
  );

  urx_control i_ctl (
    .clk(clk), .rstN(rstN), .sevenBit(sevenBit), .parityEn(parityEn),
    .evt(evt), .ctl(ctl)
  );
endmodule

// File: rtl/urx_checker.sv
module urx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sevenBit,
  input logic       parityEn,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       frameErr,
  input logic       parityErr
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r9_flags_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr || parityErr) |-> rxValid);

  a_r7_top_bit_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && sevenBit) |-> !rxData[7]);

  a_r8_no_parity_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityEn) |-> !parityErr);

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!rxValid && !frameErr && !parityErr));
endmodule

bind uart_frac_rx urx_checker i_chk (
  .clk(clk), .rstN(rstN), .sevenBit(sevenBit), .parityEn(parityEn),
  .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr), .parityErr(parityErr)
);

// File: tb/test_uart_frac_rx.sv
`timescale 1ns/1ps
module test_uart_frac_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [23:0] divisor = 24'd4096;
  logic [1:0]  osrSel = 2'd0;
  logic        sevenBit = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic [7:0]  rxData;
  logic        rxValid, frameErr, parityErr;

  int testsRun = 0, testsFailed = 0, cycles = 0;
  logic [9:0] expQ[$];   // {parityErr, frameErr, data}
  string      tagQ[$];

  always #2.5 clk = ~clk;

  uart_frac_rx i_uart_frac_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .divisor(divisor), .osrSel(osrSel),
    .sevenBit(sevenBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr), .parityErr(parityErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference comparison on every clock: each valid pulse must match the next queued frame.
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (expQ.size() == 0) check("R1 unexpected valid", {22'd0, parityErr, frameErr, rxData}, 32'h3ff);
      else begin
        logic [9:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {22'd0, parityErr, frameErr, rxData}, {22'd0, e});
      end
    end else if (rstN) begin
      if (frameErr || parityErr) check("R9 flag without valid", {30'd0, parityErr, frameErr}, 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // Send one frame with a transmitter period dtx (1/256 clock units).
  task automatic sendFrame(input string tag, input logic [7:0] d, input int dtx,
                           input bit badPar, input bit badStop, input int glitchBit,
                           input int gapClocks);
    int  bits[12];
    int  nb = 0, acc = 0;
    int  nData;
    logic p, mask;
    logic [7:0] expD;
    nData = sevenBit ? 7 : 8;
    bits[nb++] = 0;
    p = 1'b0;
    for (int i = 0; i < nData; i++) begin bits[nb++] = d[i]; p ^= d[i]; end
    if (parityEn) bits[nb++] = int'(p ^ parityOdd ^ badPar);
    bits[nb++] = badStop ? 0 : 1;
    mask = sevenBit ? 1'b0 : 1'b1;
    expD = {d[7] & mask, d[6:0]};
    expQ.push_back({parityEn & badPar, badStop, expD});
    tagQ.push_back(tag);
    for (int b = 0; b < nb; b++) begin
      int t0, t1;
      t0 = (acc + 128) >>> 8;
      acc += dtx;
      t1 = (acc + 128) >>> 8;
      for (int c = 0; c < t1 - t0; c++) begin
        @(negedge clk);
        rxLine = (b == glitchBit && c == (t1 - t0) / 2) ? ~bits[b][0] : bits[b][0];
      end
    end
    if (badStop) repeat (40) @(negedge clk);  // line held low after the bad stop bit
    for (int c = 0; c < gapClocks; c++) begin @(negedge clk); rxLine = 1'b1; end
    @(negedge clk);
    rxLine = 1'b1;
  endtask

  task automatic settle(input string tag);
    repeat (120) @(negedge clk);
    check(tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 valid", rxValid, 0);
    check("R10 data", rxData, 0);
    check("R10 flags", {frameErr, parityErr}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R10 quiet after reset", {rxValid, frameErr, parityErr}, 0);

    // R1, R3: 16x integer period
    divisor = 24'd4096; osrSel = 2'd0;
    sendFrame("R1 16x 0x55", 8'h55, 4096, 0, 0, -1, 5);
    sendFrame("R1 16x 0xA3", 8'hA3, 4096, 0, 0, -1, 5);
    sendFrame("R1 16x 0x00", 8'h00, 4096, 0, 0, -1, 5);
    sendFrame("R1 16x 0xFF", 8'hFF, 4096, 0, 0, -1, 5);
    settle("R1 all frames seen");

    // R4: glitches at bit centres, 16x and 8x
    sendFrame("R4 glitch 16x bit3", 8'h0F, 4096, 0, 0, 3, 5);
    sendFrame("R4 glitch 16x bit6", 8'hC6, 4096, 0, 0, 6, 5);
    osrSel = 2'd1;
    sendFrame("R4 glitch 8x bit2", 8'h5A, 4096, 0, 0, 2, 5);
    settle("R4 all frames seen");

    // R5: false starts
    osrSel = 2'd0;
    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk); rxLine = 1'b1;
    repeat (60) @(negedge clk);
    @(negedge clk); rxLine = 1'b0;
    repeat (6) @(negedge clk); rxLine = 1'b1;
    repeat (60) @(negedge clk);
    check("R5 no valid after false start", expQ.size(), 0);
    sendFrame("R5 frame after false start", 8'h3C, 4096, 0, 0, -1, 5);
    settle("R5 frame seen");

    // R2: fractional 10.5 clocks per bit, 8x
    divisor = 24'd2688; osrSel = 2'd1;
    sendFrame("R2 10.5 0x96", 8'h96, 2688, 0, 0, -1, 3);
    sendFrame("R2 10.5 0x01", 8'h01, 2688, 0, 0, -1, 3);
    sendFrame("R2 10.5 0x80", 8'h80, 2688, 0, 0, -1, 3);
    settle("R2 10.5 frames seen");

    // R2, R3: 874/256 clocks per bit, centre-only mode
    divisor = 24'd874; osrSel = 2'd2;
    sendFrame("R2 3.41 0xE7", 8'hE7, 874, 0, 0, -1, 0);
    sendFrame("R2 3.41 0x18", 8'h18, 874, 0, 0, -1, 0);
    sendFrame("R3 3.41 0x6B", 8'h6B, 874, 0, 0, -1, 2);
    settle("R2 3.41 frames seen");

    // R6: transmitter 3% fast and slow, back-to-back, variable gaps
    divisor = 24'd4096; osrSel = 2'd0;
    sendFrame("R6 slow 0xA5", 8'hA5, 4224, 0, 0, -1, 0);
    sendFrame("R6 slow 0x7E", 8'h7E, 4224, 0, 0, -1, 3);
    sendFrame("R6 slow 0x81", 8'h81, 4224, 0, 0, -1, 0);
    sendFrame("R6 fast 0xC3", 8'hC3, 3968, 0, 0, -1, 0);
    sendFrame("R6 fast 0x3F", 8'h3F, 3968, 0, 0, -1, 7);
    sendFrame("R6 fast 0xFE", 8'hFE, 3968, 0, 0, -1, 0);
    settle("R6 frames seen");

    // R7, R8: seven bits with parity
    sevenBit = 1'b1; parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame("R7 even ok 0x41", 8'hC1, 4096, 0, 0, -1, 5);
    sendFrame("R8 even bad 0x33", 8'h33, 4096, 1, 0, -1, 5);
    parityOdd = 1'b1;
    sendFrame("R8 odd ok 0x55", 8'h55, 4096, 0, 0, -1, 5);
    sendFrame("R8 odd bad 0x7F", 8'h7F, 4096, 1, 0, -1, 5);
    settle("R8 frames seen");
    sevenBit = 1'b0; parityEn = 1'b0;
    sendFrame("R7 eight bits 0xC1", 8'hC1, 4096, 0, 0, -1, 5);
    settle("R7 frame seen");

    // R9: framing error, then line held low, then a good frame
    sendFrame("R9 frame error 0x24", 8'h24, 4096, 0, 1, -1, 20);
    sendFrame("R9 recovery 0x99", 8'h99, 4096, 0, 0, -1, 5);
    settle("R9 frames seen");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule